// File: doc/BRIEF.md
# BCD Up/Down Decade Counter

A single decimal digit counter that steps up or down on the rising clock edge and can be chained into a multi-digit counter. The count advances only while the active-low enable is low. A direction input picks up or down counting. An asynchronous clear forces the digit to zero and overrides every other input. Below the clear, a level-sensitive parallel load forces the digit to a 4-bit value.

The parallel load works as an output bypass. While the load is high, the output follows the parallel value combinationally, and the internal register captures that value on every clock edge. When the load is released, the register keeps the last value it captured.

An active-low terminal count output flags the last digit of the current direction, and only while the enable is low. To build a wider counter, feed each digit's terminal count into the enable of the next more significant digit and drive all digits from one clock.

Top module: `bcd_updown_decade`

## Requirements
- R1: While `clr_i` is high, `cnt_o` is 0000 whatever the load, enable, direction and parallel inputs are. This holds immediately and across clock edges.
- R2: While `load_i` is high and `clr_i` is low, `cnt_o` equals `par_i` combinationally, before any clock edge and whatever `en_ni`, `up_i` and the clock do.
- R3: After `load_i` falls, the digit holds the last value captured while loading, as long as the enable stays high.
- R4: With `load_i` low and `en_ni` high, a rising clock edge leaves `cnt_o` unchanged.
- R5: With `load_i` and `en_ni` low and `up_i` high, a value from 0 to 8 increases by one on the rising edge.
- R6: With `load_i`, `en_ni` and `up_i` low, a value from 1 to 15 decreases by one on the rising edge.
- R7: Counting up from 9 gives 0, and counting down from 0 gives 9, both on a single edge.
- R8: When `up_i` is high and `en_ni` is low, `tc_no` is low exactly when bits 0 and 3 of `cnt_o` are both 1, which is the value 9.
- R9: When `up_i` is low and `en_ni` is low, `tc_no` is low exactly when `cnt_o` is 0000.
- R10: When `en_ni` is high, `tc_no` is high for every value.
- R11: From a non-decimal code (10 to 15), counting up adds one in binary and 15 goes to 0. Counting down subtracts one in binary.
- R12: When digits share one clock and each digit's `tc_no` drives the next digit's `en_ni`, the chain counts as a multi-digit decimal number in both directions and wraps at its full range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Count clock, rising edge |
| clr_i | input | 1 | Asynchronous clear, active high, highest priority |
| load_i | input | 1 | Asynchronous level-sensitive parallel load, active high |
| en_ni | input | 1 | Count enable, active low |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| par_i | input | 4 | Parallel load value |
| cnt_o | output | 4 | Current digit value |
| tc_no | output | 1 | Terminal count, active low, gated by the enable |

## Verification
The single digit is exercised in several ways, and each one separates one behaviour from the others:
- Runs of up and down counting through both wrap points separate the decimal wrap from plain binary wrap.
- Loads of the codes 12 and 14, followed by counting, separate binary stepping outside the decimal range from any forced return to 0.
- Stretches with the enable high, in both directions, show that the terminal count is gated and that the value holds.
- Clear asserted together with load shows the priority between them.
- A load checked halfway through a clock period separates the asynchronous bypass from a captured value.

A three-digit chain counts through more than its full range, up and then down, and is compared every cycle against an integer modulo 1000. This catches ripple-enable errors that a single digit cannot reveal.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
  localparam int unsigned DIGIT_W   = 4;
  localparam int unsigned DIGIT_MAX = 9;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } cnt_dir_e;
endpackage

// File: rtl/bcd_step.sv
module bcd_step
  import bcd_cnt_pkg::*;
#(
  parameter int unsigned W   = DIGIT_W,
  parameter int unsigned MAX = DIGIT_MAX
) (
  input  logic [W-1:0] cur_i,
  input  cnt_dir_e     dir_i,
  output logic [W-1:0] nxt_o
);
  localparam logic [W-1:0] LastVal = W'(MAX);

  // codes above LastVal step in plain binary; the W-bit add wraps the top code to zero
  always_comb begin
    if (dir_i == DIR_UP) begin
      nxt_o = (cur_i == LastVal) ? '0 : cur_i + W'(1);
    end else begin
      nxt_o = (cur_i == '0) ? LastVal : cur_i - W'(1);
    end
  end
endmodule

// File: rtl/bcd_tc_decode.sv
module bcd_tc_decode
  import bcd_cnt_pkg::*;
#(
  parameter int unsigned W   = DIGIT_W,
  parameter int unsigned MAX = DIGIT_MAX
) (
  input  logic [W-1:0] val_i,
  input  cnt_dir_e     dir_i,
  input  logic         en_ni,
  output logic         tc_no
);
  localparam logic [W-1:0] LastVal = W'(MAX);

  logic hit_up, hit_dn;

  // up decode looks only at the bits set in LastVal
  assign hit_up = &(val_i | ~LastVal);
  assign hit_dn = (val_i == '0);
  assign tc_no  = ~(~en_ni & ((dir_i == DIR_UP) ? hit_up : hit_dn));
endmodule

// File: rtl/bcd_digit_reg.sv
module bcd_digit_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic         en_ni,
  input  logic [W-1:0] par_i,
  input  logic [W-1:0] nxt_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or posedge clr_i) begin
    if (clr_i) begin
      q_o <= '0;
    end else if (load_i) begin
      q_o <= par_i;
    end else if (!en_ni) begin
      q_o <= nxt_i;
    end
  end
endmodule

// File: rtl/bcd_updown_decade.sv
module bcd_updown_decade
  import bcd_cnt_pkg::*;
#(
  parameter int unsigned W   = DIGIT_W,
  parameter int unsigned MAX = DIGIT_MAX
) (
  input  logic         clk_i,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic         en_ni,
  input  logic         up_i,
  input  logic [W-1:0] par_i,
  output logic [W-1:0] cnt_o,
  output logic         tc_no
);
  cnt_dir_e     dir;
  logic [W-1:0] q, nxt;

  assign dir = cnt_dir_e'(up_i);

  bcd_step #(.W(W), .MAX(MAX)) i_step (
    .cur_i (q),
    .dir_i (dir),
    .nxt_o (nxt)
  );

  bcd_digit_reg #(.W(W)) i_reg (
    .clk_i  (clk_i),
    .clr_i  (clr_i),
    .load_i (load_i),
    .en_ni  (en_ni),
    .par_i  (par_i),
    .nxt_i  (nxt),
    .q_o    (q)
  );

  // load bypass sits below the clear
  assign cnt_o = clr_i ? '0 : (load_i ? par_i : q);

  bcd_tc_decode #(.W(W), .MAX(MAX)) i_tc (
    .val_i (cnt_o),
    .dir_i (dir),
    .en_ni (en_ni),
    .tc_no (tc_no)
  );
endmodule

// File: rtl/bcd_updown_decade_chk.sv
module bcd_updown_decade_chk #(
  parameter int unsigned W   = 4,
  parameter int unsigned MAX = 9
) (
  input logic         clk_i,
  input logic         clr_i,
  input logic         load_i,
  input logic         en_ni,
  input logic         up_i,
  input logic [W-1:0] par_i,
  input logic [W-1:0] cnt_o,
  input logic         tc_no
);
  localparam logic [W-1:0] LastVal = W'(MAX);

  assert_clear_zero_R1: assert property (@(posedge clk_i) disable iff (clr_i)
    $fell(clr_i) |-> (load_i || cnt_o == '0));

  assert_load_bypass_R2: assert property (@(posedge clk_i) disable iff (clr_i)
    load_i |-> cnt_o == par_i);

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (clr_i)
    (!load_i && en_ni) |=> (load_i || cnt_o == $past(cnt_o)));

  assert_up_step_R5: assert property (@(posedge clk_i) disable iff (clr_i)
    (!load_i && !en_ni && up_i && cnt_o < LastVal) |=>
      (load_i || cnt_o == $past(cnt_o) + W'(1)));

  assert_down_step_R6: assert property (@(posedge clk_i) disable iff (clr_i)
    (!load_i && !en_ni && !up_i && cnt_o != '0) |=>
      (load_i || cnt_o == $past(cnt_o) - W'(1)));

  assert_up_wrap_R7: assert property (@(posedge clk_i) disable iff (clr_i)
    (!load_i && !en_ni && up_i && cnt_o == LastVal) |=> (load_i || cnt_o == '0));

  assert_down_wrap_R7: assert property (@(posedge clk_i) disable iff (clr_i)
    (!load_i && !en_ni && !up_i && cnt_o == '0) |=> (load_i || cnt_o == LastVal));

  assert_tc_up_R8: assert property (@(posedge clk_i) disable iff (clr_i)
    (!en_ni && up_i) |-> (tc_no == !(cnt_o[0] && cnt_o[W-1])));

  assert_tc_down_R9: assert property (@(posedge clk_i) disable iff (clr_i)
    (!en_ni && !up_i) |-> (tc_no == (cnt_o != '0)));

  assert_tc_gated_R10: assert property (@(posedge clk_i) disable iff (clr_i)
    en_ni |-> tc_no);

  assert_binary_up_R11: assert property (@(posedge clk_i) disable iff (clr_i)
    (!load_i && !en_ni && up_i && cnt_o > LastVal) |=>
      (load_i || cnt_o == $past(cnt_o) + W'(1)));
endmodule

bind bcd_updown_decade bcd_updown_decade_chk #(.W(W), .MAX(MAX)) i_chk (
  .clk_i  (clk_i),
  .clr_i  (clr_i),
  .load_i (load_i),
  .en_ni  (en_ni),
  .up_i   (up_i),
  .par_i  (par_i),
  .cnt_o  (cnt_o),
  .tc_no  (tc_no)
);

// File: tb/test_bcd_updown_decade.sv
module test_bcd_updown_decade;
  localparam time CLK_PERIOD = 10;
  localparam int  NDIG       = 3;

  typedef struct {
    logic [3:0] cnt;
    logic       tc_n;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       clr = 1'b1, load = 1'b0, en_n = 1'b1, up = 1'b1;
  logic [3:0] par = 4'd0;
  logic [3:0] cnt;
  logic       tc_n;

  int   n_chk  = 0;
  int   n_fail = 0;
  exp_t sb_q[$];
  logic [3:0] m = 4'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_updown_decade i_bcd_updown_decade (
    .clk_i (clk), .clr_i (clr), .load_i (load), .en_ni (en_n),
    .up_i (up), .par_i (par), .cnt_o (cnt), .tc_no (tc_n)
  );

  // three-digit chain
  logic            c_clr = 1'b1, c_en_n = 1'b1, c_up = 1'b1;
  logic [3:0]      c_dig [NDIG];
  logic [NDIG:0]   c_en;

  assign c_en[0] = c_en_n;
  for (genvar k = 0; k < NDIG; k++) begin : g_chain
    bcd_updown_decade i_dig (
      .clk_i (clk), .clr_i (c_clr), .load_i (1'b0), .en_ni (c_en[k]),
      .up_i (c_up), .par_i (4'd0), .cnt_o (c_dig[k]), .tc_no (c_en[k+1])
    );
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: apply inputs at the falling edge, predict the state after the next rising edge
  task automatic step(input logic c, input logic l, input logic e, input logic u,
                      input logic [3:0] p, input string tag);
    exp_t x;
    @(negedge clk);
    clr = c; load = l; en_n = e; up = u; par = p;
    #1;
    if (c) check(cnt == 4'd0, {tag, " clear immediate"}, cnt, 0);
    else if (l) check(cnt == p, {tag, " load bypass"}, cnt, p);
    if (c) m = 4'd0;
    else if (l) m = p;
    else if (!e) m = u ? ((m == 4'd9) ? 4'd0 : m + 4'd1) : ((m == 4'd0) ? 4'd9 : m - 4'd1);
    x.cnt  = m;
    x.tc_n = !(!e && (u ? (m[0] && m[3]) : (m == 4'd0)));
    x.tag  = tag;
    sb_q.push_back(x);
  endtask

  // monitor: compare a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      while (sb_q.size() > 0) begin
        exp_t x;
        x = sb_q.pop_front();
        check(cnt == x.cnt, {x.tag, " count"}, cnt, x.cnt);
        check(tc_n == x.tc_n, {x.tag, " tc_n"}, tc_n, x.tc_n);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int v;
    // R1: clear, also against load
    step(1, 0, 1, 1, 4'd0, "R1");
    step(1, 1, 0, 0, 4'd7, "R1 over load");
    step(0, 0, 1, 1, 4'd0, "R4 after clear");
    // R5 R7 R8: up through the wrap
    for (int i = 0; i < 12; i++) step(0, 0, 0, 1, 4'd0, "R5 R7 R8 up");
    // R4 R10: hold with enable high in both directions
    for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 4'd0, "R4 R10 hold up");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 4'd0, "R4 R10 hold down");
    // R6 R7 R9: down through the wrap
    for (int i = 0; i < 12; i++) step(0, 0, 0, 0, 4'd0, "R6 R7 R9 down");
    // R2 R3: load then release with enable high
    step(0, 1, 1, 1, 4'd5, "R2 load");
    step(0, 1, 0, 0, 4'd3, "R2 load ignores enable");
    step(0, 1, 0, 1, 4'd3, "R2 load ignores clock");
    step(0, 0, 1, 1, 4'd0, "R3 release");
    step(0, 0, 1, 0, 4'd9, "R3 release hold");
    // R11: non-decimal codes
    step(0, 1, 1, 1, 4'd12, "R11 load 12");
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 4'd0, "R11 up binary");
    step(0, 1, 1, 0, 4'd14, "R11 load 14");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 4'd0, "R11 down binary");
    step(1, 0, 0, 1, 4'd0, "R1 clear mid run");
    step(0, 0, 1, 1, 4'd0, "R4 idle");
    @(negedge clk);
    @(negedge clk);

    // R12: chain up then down against an integer model
    v = 0;
    @(negedge clk);
    c_clr = 1'b0;
    c_en_n = 1'b0;
    c_up = 1'b1;
    for (int i = 0; i < 1100; i++) begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      v = (v + 1) % 1000;
      check(c_dig[2] * 100 + c_dig[1] * 10 + c_dig[0] == v, "R12 chain up",
            c_dig[2] * 100 + c_dig[1] * 10 + c_dig[0], v);
    end
    @(negedge clk);
    c_up = 1'b0;
    for (int i = 0; i < 1100; i++) begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      v = (v + 999) % 1000;
      check(c_dig[2] * 100 + c_dig[1] * 10 + c_dig[0] == v, "R12 chain down",
            c_dig[2] * 100 + c_dig[1] * 10 + c_dig[0], v);
    end
    @(negedge clk);
    c_en_n = 1'b1;
    finish_run();
  end
endmodule